// File: doc/BRIEF.md
# Debug Core Select Chain

This block lets a boundary-scan debugger pick which of several on-chip cores take part in later debug operations. Each core owns one select cell, and the cells form a serial chain between TDI and TDO. While the core-select instruction is active, the debugger loads the chain through the normal capture, shift and update steps of a data register. The updated cell values become per-core select bits.

Later enable and debug-request instructions reach only the cores whose select bit is set. Each one becomes a one-cycle pulse on the per-core outputs. A debug request that arrives while core reset is held does not depend on the selection. It is remembered and released to every core as soon as reset ends.

There is no streaming data path. Every pin is plain control, sampled on the rising edge of TCK. The one exception is TDO, which is driven on the falling edge.

Top module: `dbg_core_sel_chain`

## Requirements
- R1: The chain holds exactly NUM_CORES bits between TDI and TDO. A bit enters at TDI and reaches TDO at the falling edge that follows its NUM_CORES-th shift edge.
- R2: Shifting a 1 first and then NUM_CORES-1 zeros, followed by an update, sets only core_sel[NUM_CORES-1]. That is the cell nearest TDO.
- R3: Shifting 1,0,1,0 and then zeros sets both core_sel[NUM_CORES-1] and core_sel[NUM_CORES-3].
- R4: While core_rst is high, every select bit and every pulse output reads 0 after the next TCK rising edge.
- R5: A capture edge loads each cell's shift stage with its current select bit. Shifting then presents core_sel[NUM_CORES-1] first on TDO, then core_sel[NUM_CORES-2], and so on.
- R6: core_sel changes only on a rising edge where update is strobed with the select instruction active. It holds through capture and shift.
- R7: A high en_instr or dbgreq_instr at a rising edge gives, after that edge, a one-cycle pulse on core_en_pulse or core_dbg_pulse. The pulse appears only on the bits where core_sel was set.
- R8: A dbgreq_instr seen while core_rst is high is held pending. At the first rising edge with core_rst low, core_dbg_pulse goes all ones for one cycle, whatever core_sel holds.
- R9: While core_rst is high, capture, shift and update strobes under the select instruction are ignored. Select bits stay 0 once reset ends.
- R10: sel_shift_active is high exactly while sel_instr and shift_dr are high and core_rst is low.
- R11: TDO changes only on falling TCK edges. Just after a rising edge it still shows the value from the previous falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| core_rst | input | 1 | Core reset, active high, sampled on TCK |
| tdi | input | 1 | Serial data in |
| cap_dr | input | 1 | Capture data register strobe |
| shift_dr | input | 1 | Shift data register strobe |
| upd_dr | input | 1 | Update data register strobe |
| sel_instr | input | 1 | Core-select instruction is current |
| en_instr | input | 1 | Enable-debug instruction strobe |
| dbgreq_instr | input | 1 | Debug-request instruction strobe |
| tdo | output | 1 | Serial data out, driven on falling TCK |
| core_sel | output | NUM_CORES | Per-core select bits |
| core_en_pulse | output | NUM_CORES | Per-core enable pulse |
| core_dbg_pulse | output | NUM_CORES | Per-core debug-request pulse |
| sel_shift_active | output | 1 | Select chain is shifting |

## Verification
The bench targets the shift ordering. A chain wired in the reverse direction would set core 0 for the single-one pattern and would also show the captured bits backwards on TDO. It sends a debug request inside reset while no core is selected. A design that gates that request with the selection would pulse no core at release, and one that forgets to clear the pending flag would pulse twice. It also strobes the select instruction during reset, which catches a design that lets those strobes load the chain. Finally, it compares core_sel on every clock during capture and shift, which catches cells that load their select bit too early.

// File: rtl/dbg_sel_pkg.sv
package dbg_sel_pkg;
  // operation applied to every select cell on a TCK rising edge
  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_CAPTURE = 2'd1,
    OP_SHIFT   = 2'd2,
    OP_UPDATE  = 2'd3
  } sel_op_e;
endpackage

// File: rtl/dbg_sel_cell.sv
module dbg_sel_cell
  import dbg_sel_pkg::*;
(
  input  logic    tck,
  input  logic    rst,
  input  sel_op_e op,
  input  logic    scan_in,
  output logic    scan_out,
  output logic    sel_q
);
  logic stage_q;

  always_ff @(posedge tck) begin
    if (rst) begin
      stage_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      case (op)
        OP_CAPTURE: stage_q <= sel_q;
        OP_SHIFT:   stage_q <= scan_in;
        OP_UPDATE:  sel_q   <= stage_q;
        default:    stage_q <= stage_q;
      endcase
    end
  end

  assign scan_out = stage_q;

  // select bit moves only on update
  assert_hold_sel_R6: assert property (@(posedge tck) disable iff (rst)
    (op != OP_UPDATE) |=> $stable(sel_q));

  // capture copies the select bit into the shift stage
  assert_capture_R5: assert property (@(posedge tck) disable iff (rst)
    (op == OP_CAPTURE) |=> (scan_out == $past(sel_q)));
endmodule

// File: rtl/dbg_sel_pulse_gen.sv
module dbg_sel_pulse_gen #(
  parameter int NUM_CORES = 4
) (
  input  logic                 tck,
  input  logic                 rst,
  input  logic                 en_instr,
  input  logic                 dbgreq_instr,
  input  logic [NUM_CORES-1:0] sel,
  output logic [NUM_CORES-1:0] en_pulse,
  output logic [NUM_CORES-1:0] dbg_pulse
);
  localparam logic [NUM_CORES-1:0] ALL_CORES = {NUM_CORES{1'b1}};

  logic pend_q;

  always_ff @(posedge tck) begin
    if (rst) begin
      en_pulse  <= '0;
      dbg_pulse <= '0;
      pend_q    <= pend_q | dbgreq_instr;
    end else begin
      en_pulse  <= en_instr ? sel : '0;
      if (pend_q)
        dbg_pulse <= ALL_CORES;
      else
        dbg_pulse <= dbgreq_instr ? sel : '0;
      pend_q    <= 1'b0;
    end
  end

  assert_en_gated_R7: assert property (@(posedge tck) disable iff (rst)
    (|en_pulse) |-> ((en_pulse & ~$past(sel)) == '0));

  assert_dbg_gated_R7: assert property (@(posedge tck) disable iff (rst)
    ((|dbg_pulse) && !$past(pend_q)) |-> ((dbg_pulse & ~$past(sel)) == '0));

  assert_pending_release_R8: assert property (@(posedge tck) disable iff (rst)
    pend_q |=> (dbg_pulse == ALL_CORES) && !pend_q);
endmodule

// File: rtl/dbg_sel_tdo_out.sv
module dbg_sel_tdo_out (
  input  logic tck,
  input  logic scan_bit,
  output logic tdo
);
  always_ff @(negedge tck) begin
    tdo <= scan_bit;
  end
endmodule

// File: rtl/dbg_core_sel_chain.sv
module dbg_core_sel_chain
  import dbg_sel_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 tck,
  input  logic                 core_rst,
  input  logic                 tdi,
  input  logic                 cap_dr,
  input  logic                 shift_dr,
  input  logic                 upd_dr,
  input  logic                 sel_instr,
  input  logic                 en_instr,
  input  logic                 dbgreq_instr,
  output logic                 tdo,
  output logic [NUM_CORES-1:0] core_sel,
  output logic [NUM_CORES-1:0] core_en_pulse,
  output logic [NUM_CORES-1:0] core_dbg_pulse,
  output logic                 sel_shift_active
);
  localparam int LAST = NUM_CORES - 1;

  sel_op_e              op;
  logic [NUM_CORES-1:0] stage;

  always_comb begin
    op = OP_HOLD;
    if (sel_instr && !core_rst) begin
      if (cap_dr)        op = OP_CAPTURE;
      else if (shift_dr) op = OP_SHIFT;
      else if (upd_dr)   op = OP_UPDATE;
    end
  end

  // cell 0 sits at TDI, cell LAST sits at TDO
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_cell
    logic link_in;
    if (i == 0) begin : g_head
      assign link_in = tdi;
    end else begin : g_body
      assign link_in = stage[i-1];
    end
    dbg_sel_cell u_cell (
      .tck      (tck),
      .rst      (core_rst),
      .op       (op),
      .scan_in  (link_in),
      .scan_out (stage[i]),
      .sel_q    (core_sel[i])
    );
  end

  dbg_sel_pulse_gen #(.NUM_CORES(NUM_CORES)) u_pulse (
    .tck          (tck),
    .rst          (core_rst),
    .en_instr     (en_instr),
    .dbgreq_instr (dbgreq_instr),
    .sel          (core_sel),
    .en_pulse     (core_en_pulse),
    .dbg_pulse    (core_dbg_pulse)
  );

  dbg_sel_tdo_out u_tdo (
    .tck      (tck),
    .scan_bit (stage[LAST]),
    .tdo      (tdo)
  );

  assign sel_shift_active = sel_instr & shift_dr & ~core_rst;

  assert_reset_clear_R4: assert property (@(posedge tck)
    core_rst |=> (core_sel == '0) && (core_en_pulse == '0));
endmodule

// File: tb/dbg_core_sel_chain_test.sv
module dbg_core_sel_chain_test;
  localparam int N = 4;

  logic tck = 1'b0;
  logic core_rst = 1'b1;
  logic tdi = 1'b0, cap_dr = 1'b0, shift_dr = 1'b0, upd_dr = 1'b0;
  logic sel_instr = 1'b0, en_instr = 1'b0, dbgreq_instr = 1'b0;
  logic tdo, sel_shift_active;
  logic [N-1:0] core_sel, core_en_pulse, core_dbg_pulse;

  int checks = 0;
  int fails = 0;
  bit model_ok = 0;
  bit finished = 0;

  // reference model state
  bit m_sel[N];
  bit m_q[$];        // front is the TDO end
  bit m_pend = 0;
  bit m_en[N];
  bit m_dbg[N];
  bit m_tdo = 0;

  always #4 tck = ~tck;

  dbg_core_sel_chain #(.NUM_CORES(N)) uut (
    .tck(tck), .core_rst(core_rst), .tdi(tdi), .cap_dr(cap_dr),
    .shift_dr(shift_dr), .upd_dr(upd_dr), .sel_instr(sel_instr),
    .en_instr(en_instr), .dbgreq_instr(dbgreq_instr), .tdo(tdo),
    .core_sel(core_sel), .core_en_pulse(core_en_pulse),
    .core_dbg_pulse(core_dbg_pulse), .sel_shift_active(sel_shift_active)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pack(input bit v[N]);
    int r = 0;
    for (int i = 0; i < N; i++) if (v[i]) r |= (1 << i);
    return r;
  endfunction

  // model advances on each rising edge
  always @(posedge tck) begin
    bit old_sel[N];
    old_sel = m_sel;
    if (core_rst) begin
      for (int i = 0; i < N; i++) begin m_sel[i] = 0; m_en[i] = 0; m_dbg[i] = 0; end
      m_q.delete();
      for (int i = 0; i < N; i++) m_q.push_back(1'b0);
      if (dbgreq_instr) m_pend = 1;
    end else begin
      for (int i = 0; i < N; i++) begin
        m_en[i]  = en_instr & old_sel[i];
        m_dbg[i] = m_pend ? 1'b1 : (dbgreq_instr & old_sel[i]);
      end
      m_pend = 0;
      if (sel_instr && cap_dr) begin
        for (int i = 0; i < N; i++) m_q[i] = old_sel[N-1-i];
      end else if (sel_instr && shift_dr) begin
        void'(m_q.pop_front());
        m_q.push_back(tdi);
      end else if (sel_instr && upd_dr) begin
        for (int i = 0; i < N; i++) m_sel[N-1-i] = m_q[i];
      end
    end
    model_ok = 1;
    #1;
    check("R11 tdo steady after rising edge", tdo, m_tdo);
  end

  always @(negedge tck) begin
    if (model_ok) begin
      m_tdo = m_q[0];
      #1;
      check("R6 core_sel", core_sel, pack(m_sel));
      check("R7 core_en_pulse", core_en_pulse, pack(m_en));
      check("R7 core_dbg_pulse", core_dbg_pulse, pack(m_dbg));
      check("R10 sel_shift_active", sel_shift_active,
            int'(sel_instr & shift_dr & ~core_rst));
      check("R5 tdo", tdo, m_tdo);
    end
  end

  task automatic step();
    @(posedge tck); #2;
  endtask

  // capture, N shifts, update; pat[0] is shifted first
  task automatic scan(input logic [N-1:0] pat, output logic [N-1:0] seen,
                      output logic late);
    cap_dr = 1;
    step();
    cap_dr = 0; shift_dr = 1; tdi = pat[0];
    @(negedge tck); #1 seen[N-1] = tdo;
    for (int k = 1; k < N; k++) begin
      step();
      tdi = pat[k];
      @(negedge tck); #1 seen[N-1-k] = tdo;
    end
    step();
    shift_dr = 0; upd_dr = 1;
    @(negedge tck); #1 late = tdo;
    step();
    upd_dr = 0;
    @(negedge tck); #2;
  endtask

  initial begin
    logic [N-1:0] seen;
    logic late;
    logic [N-1:0] prev;
    // reset phase with strobes that must be ignored
    step(); step();
    @(negedge tck); #2;
    check("R4 reset sel", core_sel, 0);
    check("R4 reset pulses", core_en_pulse | core_dbg_pulse, 0);
    sel_instr = 1;
    scan(4'b1111, seen, late);
    check("R9 sel after reset scan", core_sel, 0);
    sel_instr = 0;
    step();
    dbgreq_instr = 1;
    step();
    dbgreq_instr = 0;
    step();
    core_rst = 0;
    @(posedge tck); @(negedge tck); #2;
    check("R8 release pulse all cores", core_dbg_pulse, (1 << N) - 1);
    check("R9 sel still clear", core_sel, 0);
    @(negedge tck); #2;
    check("R8 single pulse", core_dbg_pulse, 0);

    // single selection
    step();
    sel_instr = 1;
    scan(4'b0001, seen, late);
    check("R2 only last core", core_sel, 1 << (N-1));
    check("R1 first bit reaches tdo", late, 1);
    prev = core_sel;

    // multi selection, previous selection comes out of tdo
    scan(4'b0101, seen, late);
    check("R5 captured selection on tdo", seen, prev);
    check("R3 two cores", core_sel, (1 << (N-1)) | (1 << (N-3)));
    check("R1 first bit reaches tdo", late, 1);
    prev = core_sel;
    sel_instr = 0;

    // enable and debug request gated by selection
    en_instr = 1;
    step();
    en_instr = 0;
    @(negedge tck); #2;
    check("R7 enable to selected", core_en_pulse, prev);
    dbgreq_instr = 1;
    step();
    dbgreq_instr = 0;
    @(negedge tck); #2;
    check("R7 debug to selected", core_dbg_pulse, prev);

    // other patterns
    sel_instr = 1;
    scan(4'b0110, seen, late);
    check("R5 captured selection on tdo", seen, prev);
    check("R1 first bit reaches tdo", late, 0);
    scan(4'b0000, seen, late);
    check("R4 deselect all", core_sel, 0);
    sel_instr = 0;
    en_instr = 1;
    step();
    en_instr = 0;
    @(negedge tck); #2;
    check("R7 no enable when none selected", core_en_pulse, 0);

    // reset clears a live selection
    sel_instr = 1;
    scan(4'b1010, seen, late);
    sel_instr = 0;
    core_rst = 1;
    step();
    @(negedge tck); #2;
    check("R4 reset clears selection", core_sel, 0);
    core_rst = 0;
    step(); step();
    @(negedge tck); #2;
    check("R8 no pulse without request", core_dbg_pulse, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule